// File: doc/BRIEF.md
# Serial Flash Identity Probe

This block runs a single identification exchange with a serial NOR flash on an SPI link at start-up. On a start request it selects the device, sends the standard JEDEC identity opcode, and clocks three more bytes. The replies are the manufacturer code, the memory type code and the capacity code. It then judges whether the device belongs to the supported family and turns the capacity code into the number of 4 KB erase sectors the device holds.

Boot logic pulses `start_i` once after reset and waits for `done_o`. It then reads `supported_o` and `sector_count_o` to size the rest of the storage stack. The SPI shifter is built in and runs in mode 0, with the serial clock derived from the system clock by a parameterised divider. A device that is not recognised reports unsupported with a sector count of zero.

Top module: `flash_id_probe`

## Requirements
- R1: A probe shifts out, most significant bit first, the opcode 0x9F followed by three filler bytes of 0x00, 32 bits in total.
- R2: `spi_cs_no` goes low when a start is accepted and stays low for all 32 bit periods. It returns high in the same cycle that `done_o` pulses and is high whenever no probe is running. Each probe makes exactly 32 rising edges of `spi_sck_o`.
- R3: The link runs in SPI mode 0. `spi_sck_o` idles low, `spi_mosi_o` changes only after a falling edge, and `spi_miso_i` is sampled at each rising edge. The three bytes received after the opcode are taken as manufacturer, memory type and capacity, in that order.
- R4: A device is supported only when its manufacturer byte equals 0xEF.
- R5: A device is supported only when its memory type byte is 0x30, 0x40, 0x50 or 0x60.
- R6: For a supported device, capacity codes 0x14, 0x15, 0x16, 0x17 and 0x18 give sector counts of 256, 512, 1024, 2048 and 4096.
- R7: Any capacity code outside 0x14 to 0x18 makes the device unsupported.
- R8: Whenever `supported_o` is 0, `sector_count_o` is 0.
- R9: `done_o` is a one-cycle pulse. `supported_o` and `sector_count_o` are cleared to 0 when a start is accepted. They take the decoded result with the `done_o` pulse and hold it until the next accepted start.
- R10: A start request that arrives while a probe is running is ignored. The running probe still makes exactly 32 clock edges and ends with a single `done_o` pulse.
- R11: Each half period of `spi_sck_o` lasts HALF_DIV system clock cycles, so rising edges are 2*HALF_DIV cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request to run one identity probe |
| spi_sck_o | output | 1 | SPI serial clock, mode 0 |
| spi_cs_no | output | 1 | Active-low device select |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |
| done_o | output | 1 | One-cycle pulse when the probe has finished |
| supported_o | output | 1 | Device recognised and capacity understood |
| sector_count_o | output | SECT_W | Number of 4 KB erase sectors, 0 when unsupported |

## Verification
The hardest case to reach from the ports is a start request that lands in the middle of a running probe. That request must not restart the exchange, add clock edges or produce a second completion pulse. The bench raises `start_i` partway through the second byte while a behavioural flash model answers on the serial lines. It then counts every rising serial clock edge and every captured command bit across the whole select window. Failing identities are also driven: a wrong vendor, memory types just outside the accepted set, and capacity codes one step past either end of the table. Each is checked for a zero count.

// File: rtl/fid_pkg.sv
package fid_pkg;

  localparam logic [7:0] ID_OPCODE    = 8'h9F;
  localparam logic [7:0] ID_FILLER    = 8'h00;
  localparam logic [7:0] VENDOR_CODE  = 8'hEF;
  localparam logic [7:0] CAP_CODE_LO  = 8'h14;
  localparam int unsigned NUM_CAPS    = 5;
  localparam int unsigned BYTES_PER_ID = 4;

  typedef enum logic {
    PRB_IDLE = 1'b0,
    PRB_RUN  = 1'b1
  } prb_state_e;

  function automatic logic mem_type_ok(input logic [7:0] t);
    return (t == 8'h30) || (t == 8'h40) || (t == 8'h50) || (t == 8'h60);
  endfunction

endpackage

// File: rtl/fid_spi_byte.sv
module fid_spi_byte #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       active_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic             act_q, act_d;
  logic             sck_q, sck_d;
  logic             done_q, done_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       tx_q, tx_d;
  logic [7:0]       rx_q, rx_d;

  always_comb begin
    act_d  = act_q;
    sck_d  = sck_q;
    div_d  = div_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (go_i) begin
        act_d = 1'b1;
        tx_d  = tx_i;
        div_d = '0;
        bit_d = '0;
        sck_d = 1'b0;
      end
    end else if (div_q == DIV_LAST) begin
      div_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso_i};
      end else begin
        sck_d = 1'b0;
        tx_d  = {tx_q[6:0], 1'b0};
        if (bit_q == 3'd7) begin
          act_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
        end
      end
    end else begin
      div_d = div_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      sck_q  <= sck_d;
      done_q <= done_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign sck_o    = sck_q;
  assign mosi_o   = tx_q[7];
  assign active_o = act_q;
  assign done_o   = done_q;
  assign rx_o     = rx_q;

  // R3: serial clock rests low outside a byte
  a_r3_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sck_q);

  // R3: data line moves only while the serial clock is low
  a_r3_mosi_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && act_q) |=> (mosi_o == $past(mosi_o)) || !sck_q);

endmodule

// File: rtl/fid_decode.sv
module fid_decode #(
  parameter int unsigned SECT_W   = 13,
  parameter int unsigned MIN_SECT = 256
) (
  input  logic [7:0]        mfr_i,
  input  logic [7:0]        mtype_i,
  input  logic [7:0]        cap_i,
  output logic              ok_o,
  output logic [SECT_W-1:0] count_o
);
  import fid_pkg::*;

  logic [NUM_CAPS-1:0] hit;

  for (genvar g = 0; g < NUM_CAPS; g++) begin : g_cap
    assign hit[g] = (cap_i == CAP_CODE_LO + 8'(g));
  end

  always_comb begin
    count_o = '0;
    for (int i = 0; i < NUM_CAPS; i++) begin
      if (hit[i]) count_o = count_o | (SECT_W'(MIN_SECT) << i);
    end
    ok_o = (mfr_i == VENDOR_CODE) && mem_type_ok(mtype_i) && (|hit);
  end

  // R6: at most one capacity code matches, and a supported result is a single power of two
  always_comb begin
    a_r6_hit_onehot: assert ($onehot0(hit));
    if (ok_o) a_r6_count_single: assert ($countones(count_o) == 1);
  end

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned SECT_W   = 13,
  parameter int unsigned MIN_SECT = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              spi_sck_o,
  output logic              spi_cs_no,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i,
  output logic              done_o,
  output logic              supported_o,
  output logic [SECT_W-1:0] sector_count_o
);
  import fid_pkg::*;

  localparam int unsigned IDX_W = $clog2(BYTES_PER_ID);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTES_PER_ID - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  prb_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [7:0]        mfr_q, mfr_d;
  logic [7:0]        typ_q, typ_d;
  logic              csn_q, csn_d;
  logic              done_q, done_d;
  logic              sup_q, sup_d;
  logic [SECT_W-1:0] cnt_q, cnt_d;

  logic              go;
  logic [7:0]        tx_sel;
  logic              eng_active, eng_done;
  logic [7:0]        eng_rx;
  logic              dec_ok;
  logic [SECT_W-1:0] dec_cnt;

  fid_spi_byte #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .go_i     (go),
    .tx_i     (tx_sel),
    .miso_i   (spi_miso_i),
    .sck_o    (spi_sck_o),
    .mosi_o   (spi_mosi_o),
    .active_o (eng_active),
    .done_o   (eng_done),
    .rx_o     (eng_rx)
  );

  fid_decode #(.SECT_W(SECT_W), .MIN_SECT(MIN_SECT)) u_decode (
    .mfr_i   (mfr_q),
    .mtype_i (typ_q),
    .cap_i   (eng_rx),
    .ok_o    (dec_ok),
    .count_o (dec_cnt)
  );

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    mfr_d  = mfr_q;
    typ_d  = typ_q;
    csn_d  = csn_q;
    sup_d  = sup_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    go     = 1'b0;
    tx_sel = ID_FILLER;
    unique case (st_q)
      PRB_IDLE: begin
        if (start_i) begin
          go     = 1'b1;
          tx_sel = ID_OPCODE;
          st_d   = PRB_RUN;
          csn_d  = 1'b0;
          idx_d  = '0;
          sup_d  = 1'b0;
          cnt_d  = '0;
        end
      end
      PRB_RUN: begin
        if (eng_done) begin
          if (idx_q == IDX_LAST) begin
            st_d   = PRB_IDLE;
            csn_d  = 1'b1;
            done_d = 1'b1;
            sup_d  = dec_ok;
            cnt_d  = dec_ok ? dec_cnt : '0;
          end else begin
            go    = 1'b1;
            idx_d = idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(1)) mfr_d = eng_rx;
            if (idx_q == IDX_W'(2)) typ_d = eng_rx;
          end
        end
      end
      default: st_d = PRB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PRB_IDLE;
      idx_q  <= '0;
      mfr_q  <= '0;
      typ_q  <= '0;
      csn_q  <= 1'b1;
      done_q <= 1'b0;
      sup_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      mfr_q  <= mfr_d;
      typ_q  <= typ_d;
      csn_q  <= csn_d;
      done_q <= done_d;
      sup_q  <= sup_d;
      cnt_q  <= cnt_d;
    end
  end

  assign spi_cs_no      = csn_q;
  assign done_o         = done_q;
  assign supported_o    = sup_q;
  assign sector_count_o = cnt_q;

  // R2: select held low whenever the shifter is moving bits
  a_r2_cs_low_while_shifting: assert property (@(posedge clk_i) disable iff (!rst_n)
    eng_active |-> !csn_q);

  // R2: select high whenever no probe is running
  a_r2_cs_high_idle: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == PRB_IDLE) |-> csn_q);

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_q |=> !done_q);

  // R9: results hold while idle with no new request
  a_r9_results_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == PRB_IDLE && !start_i) |=> $stable(sup_q) && $stable(cnt_q));

  // R8: unsupported always reports zero sectors
  a_r8_zero_when_unsupported: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sup_q |-> (cnt_q == '0));

  // R10: a request during a running probe does not return to idle early
  a_r10_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == PRB_RUN && !eng_done) |=> (st_q == PRB_RUN));

endmodule

// File: tb/flash_id_probe_tb_top.sv
module flash_id_probe_tb_top;

  localparam int HALF = 2;
  localparam int SW   = 13;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic          spi_sck_o, spi_cs_no, spi_mosi_o, spi_miso_i;
  logic          done_o, supported_o;
  logic [SW-1:0] sector_count_o;

  int vectors = 0;
  int fails   = 0;

  always #2 clk_i = ~clk_i;

  flash_id_probe #(.HALF_DIV(HALF), .SECT_W(SW), .MIN_SECT(256)) dut_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .spi_sck_o      (spi_sck_o),
    .spi_cs_no      (spi_cs_no),
    .spi_mosi_o     (spi_mosi_o),
    .spi_miso_i     (spi_miso_i),
    .done_o         (done_o),
    .supported_o    (supported_o),
    .sector_count_o (sector_count_o)
  );

  // behavioural flash: answers from a shift word, records what it hears
  logic [31:0] resp_sh = '0;
  logic [31:0] heard   = '0;
  int          rises   = 0;
  time         t_r0, t_r1;

  assign spi_miso_i = resp_sh[31];

  always @(posedge spi_sck_o) begin
    if (!spi_cs_no) begin
      heard = {heard[30:0], spi_mosi_o};
      if (rises == 0) t_r0 = $time;
      if (rises == 1) t_r1 = $time;
      rises = rises + 1;
    end
  end

  always @(negedge spi_sck_o) begin
    if (!spi_cs_no) resp_sh = {resp_sh[30:0], 1'b0};
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_count(input logic [7:0] m, input logic [7:0] t, input logic [7:0] c);
    if (m != 8'hEF) return 0;
    if (!(t == 8'h30 || t == 8'h40 || t == 8'h50 || t == 8'h60)) return 0;
    case (c)
      8'h14: return 256;
      8'h15: return 512;
      8'h16: return 1024;
      8'h17: return 2048;
      8'h18: return 4096;
      default: return 0;
    endcase
  endfunction

  // model of held results, compared every clock while idle
  logic          m_sup;
  logic [SW-1:0] m_cnt;

  task automatic probe(input logic [7:0] m, input logic [7:0] t, input logic [7:0] c,
                       input int mid_start, input string tag);
    int n;
    int ec;
    ec = exp_count(m, t, c);
    resp_sh = {8'h00, m, t, c};
    heard = '0;
    rises = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    m_sup = 1'b0;
    m_cnt = '0;
    check("R9 cleared on accepted start", {supported_o, 19'd0, sector_count_o}, 32'd0);
    check("R2 select low after start", {31'd0, spi_cs_no}, 32'd0);
    n = 0;
    while (!done_o && n < 2000) begin
      @(negedge clk_i);
      n++;
      start_i = (mid_start != 0 && n == mid_start);
      if (!done_o) begin
        check("R2 select held during probe", {31'd0, spi_cs_no}, 32'd0);
        check("R9 results cleared during probe", {supported_o, 19'd0, sector_count_o}, 32'd0);
      end
    end
    start_i = 1'b0;
    if (!done_o) begin
      fails++;
      $display("FAIL watchdog %s: actual no done expected done", tag);
    end
    m_sup = (ec != 0);
    m_cnt = SW'(ec);
    check({tag, " supported"}, {31'd0, supported_o}, {31'd0, m_sup});
    check({tag, " sector count (R6 R7 R8)"}, {19'd0, sector_count_o}, {19'd0, m_cnt});
    check("R2 select released with done", {31'd0, spi_cs_no}, 32'd1);
    check("R2 R10 rising edges per probe", rises, 32);
    check("R1 command bits heard", heard, 32'h9F000000);
    check("R11 rising edge spacing", 32'(t_r1 - t_r0), 32'(2 * HALF * 4));
    repeat (6) begin
      @(negedge clk_i);
      check("R9 done single pulse", {31'd0, done_o}, 32'd0);
      check("R9 results held", {m_sup, 19'd0, m_cnt}, {supported_o, 19'd0, sector_count_o});
      check("R3 clock idle low", {31'd0, spi_sck_o}, 32'd0);
      check("R2 select idle high", {31'd0, spi_cs_no}, 32'd1);
    end
  endtask

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    m_sup   = 1'b0;
    m_cnt   = '0;
    repeat (3) @(negedge clk_i);
    check("reset cs", {31'd0, spi_cs_no}, 32'd1);
    check("reset outputs", {done_o, supported_o, spi_sck_o, 16'd0, sector_count_o}, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 reset state held", {done_o, supported_o, 17'd0, sector_count_o}, 32'd0);

    probe(8'hEF, 8'h40, 8'h14, 0,  "R6 cap 0x14");
    probe(8'hEF, 8'h30, 8'h18, 0,  "R6 R5 cap 0x18 type 0x30");
    probe(8'hEF, 8'h60, 8'h16, 0,  "R6 R5 cap 0x16 type 0x60");
    probe(8'hEF, 8'h50, 8'h15, 40, "R10 R6 cap 0x15 type 0x50 mid start");
    probe(8'hEF, 8'h40, 8'h17, 0,  "R6 R3 cap 0x17");
    probe(8'hC2, 8'h40, 8'h16, 0,  "R4 wrong vendor");
    probe(8'hEE, 8'h40, 8'h16, 0,  "R4 vendor near miss");
    probe(8'hEF, 8'h20, 8'h16, 0,  "R5 type 0x20");
    probe(8'hEF, 8'h70, 8'h16, 0,  "R5 type 0x70");
    probe(8'hEF, 8'h40, 8'h13, 0,  "R7 cap below range");
    probe(8'hEF, 8'h40, 8'h19, 0,  "R7 cap above range");
    probe(8'hFF, 8'hFF, 8'hFF, 0,  "R8 all ones bus");
    probe(8'hEF, 8'h60, 8'h18, 100, "R10 R6 late mid start");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule